// File: doc/BRIEF.md
# Interrupt Mask and Request Gating

This block owns the two interrupt mask flags of a small processor's status byte and picks which request, if any, is handed to the core. The first flag gates the non-maskable request. The second flag gates a vector of ordinary maskable requests. A trap request for an undefined instruction bypasses both flags. Whenever the block is idle and a request qualifies, it raises `take_o` for that cycle and reports the winning source as a kind code and an index.

After a take, the block stays busy and accepts no further request until the core signals that the status byte has been pushed to the stack. At that point the mask flags are updated in hardware according to the source that was taken. A return-from-interrupt reloads both flags from the status byte pulled off the stack. Software may clear the non-maskable flag once. It can never set that flag again.

Top module: `irq_mask_gate`

## Requirements
- R1: A synchronous reset sets both mask flags to 1 and clears the busy state. While both flags are 1, neither the non-maskable request nor any maskable request produces a take.
- R2: A software write with `sw_wr_i` high may clear the non-maskable flag. A software write of 1 to that flag leaves it unchanged. Software therefore cannot turn a 0 back into a 1.
- R3: A software write loads the maskable flag with the written value, either 0 or 1.
- R4: The non-maskable request is accepted exactly when its flag is 0, whatever the value of the maskable flag.
- R5: The non-maskable request wins over the trap request and over every maskable request. Kind codes on `src_kind_o`: 0 none, 1 maskable, 2 trap, 3 non-maskable.
- R6: Maskable requests count only while the maskable flag is 0. Among them the lowest set bit of `irq_req_i` wins, and its bit number appears on `src_idx_o` with kind 1.
- R7: The trap request is accepted whatever the values of both flags. It wins over every maskable request.
- R8: After a take, `take_o` stays low, and both flags keep their values, until `stack_done_i` is seen.
- R9: When `stack_done_i` completes a maskable or trap entry, the maskable flag becomes 1 and the non-maskable flag is left unchanged.
- R10: When `stack_done_i` completes a non-maskable entry, both flags become 1.
- R11: A return-from-interrupt with `rti_i` high loads both flags from `rti_nmi_mask_i` and `rti_irq_mask_i`. This load may set the non-maskable flag to 1.
- R12: A `stack_done_i` pulse with no entry in progress changes nothing.
- R13: If a return-from-interrupt and a software write occur in the same cycle, the return-from-interrupt wins. Completion of an entry wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req_i | input | 1 | Level-sensitive non-maskable request |
| trap_req_i | input | 1 | Undefined-instruction trap request |
| irq_req_i | input | NUM_IRQ | Maskable requests; bit 0 has the highest priority |
| sw_wr_i | input | 1 | Software write strobe for the mask flags |
| sw_nmi_mask_i | input | 1 | Written non-maskable flag value (a 1 is ignored) |
| sw_irq_mask_i | input | 1 | Written maskable flag value |
| stack_done_i | input | 1 | The status byte of the current entry has been stacked |
| rti_i | input | 1 | Return-from-interrupt restore strobe |
| rti_nmi_mask_i | input | 1 | Restored non-maskable flag |
| rti_irq_mask_i | input | 1 | Restored maskable flag |
| nmi_mask_o | output | 1 | Current non-maskable flag |
| irq_mask_o | output | 1 | Current maskable flag |
| take_o | output | 1 | A request is forwarded this cycle |
| src_kind_o | output | 2 | Kind of the winning source (0 when there is no take) |
| src_idx_o | output | IDX_W | Index of the winning maskable source, 0 otherwise |

## Verification
A wrong flag value shows on `nmi_mask_o` or `irq_mask_o` one cycle after the write, restore or completion that caused it. In the same cycle it changes whether `take_o` rises for the requests that are present. A busy state left stuck shows as `take_o` staying low even though a trap request is asserted, because a trap qualifies under every mask setting. A busy state cleared too early shows as a second take in the cycle right after the first one. A priority fault shows combinationally on `src_kind_o` and `src_idx_o` in the cycle of the take.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_MASKABLE = 2'd1,
        SRC_TRAP     = 2'd2,
        SRC_NMI      = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic nmi_mask;
        logic irq_mask;
    } mask_bits_t;

    localparam mask_bits_t MASKS_AT_RESET = '{nmi_mask: 1'b1, irq_mask: 1'b1};

    // Flag values after the status byte of an entry has been stacked
    function automatic mask_bits_t entry_masks(input src_kind_e kind, input mask_bits_t cur);
        mask_bits_t nxt;
        nxt          = cur;
        nxt.irq_mask = 1'b1;
        if (kind == SRC_NMI) begin
            nxt.nmi_mask = 1'b1;
        end
        return nxt;
    endfunction

    // Software can only ever lower the non-maskable flag
    function automatic mask_bits_t sw_masks(input mask_bits_t wr, input mask_bits_t cur);
        mask_bits_t nxt;
        nxt.nmi_mask = cur.nmi_mask & wr.nmi_mask;
        nxt.irq_mask = wr.irq_mask;
        return nxt;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_gate_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_REQ:0]   seen;
    logic [NUM_REQ-1:0] grant;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
            assign grant[g]  = req_i[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req_i[g];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (grant[k]) begin
                idx_o = idx_o | IDX_W'(k);
            end
        end
    end

    assign hit_o = seen[NUM_REQ];

    // R6: at most one maskable source is granted at a time
    assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R6: whenever any request is present, exactly one is granted
    assert_grant_when_req_R6: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |-> ($countones(grant) == 1));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       entry_set_i,
    input  src_kind_e  entry_kind_i,
    input  logic       rti_ld_i,
    input  mask_bits_t rti_val_i,
    input  logic       sw_wr_i,
    input  mask_bits_t sw_val_i,
    output mask_bits_t masks_o
);

    mask_bits_t masks_q;
    mask_bits_t masks_d;

    always_comb begin
        masks_d = masks_q;
        if (entry_set_i) begin
            masks_d = entry_masks(entry_kind_i, masks_q);
        end else if (rti_ld_i) begin
            masks_d = rti_val_i;
        end else if (sw_wr_i) begin
            masks_d = sw_masks(sw_val_i, masks_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            masks_q <= MASKS_AT_RESET;
        end else begin
            masks_q <= masks_d;
        end
    end

    assign masks_o = masks_q;

    // R2: the non-maskable flag rises only on a restore or a non-maskable entry
    assert_nmi_flag_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(masks_q.nmi_mask) |->
            $past(rti_ld_i || (entry_set_i && entry_kind_i == SRC_NMI)));

    // R9: completing any entry leaves the maskable flag set
    assert_entry_sets_irq_R9: assert property (@(posedge clk) disable iff (rst)
        entry_set_i |=> masks_q.irq_mask);

    // R9: a maskable or trap entry does not touch the non-maskable flag
    assert_entry_keeps_nmi_R9: assert property (@(posedge clk) disable iff (rst)
        (entry_set_i && entry_kind_i != SRC_NMI) |=> $stable(masks_q.nmi_mask));

    // R10: a non-maskable entry sets both flags
    assert_nmi_entry_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (entry_set_i && entry_kind_i == SRC_NMI) |=> (masks_q.nmi_mask && masks_q.irq_mask));

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
    import irq_gate_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_req_i,
    input  logic               trap_req_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic               sw_wr_i,
    input  logic               sw_nmi_mask_i,
    input  logic               sw_irq_mask_i,
    input  logic               stack_done_i,
    input  logic               rti_i,
    input  logic               rti_nmi_mask_i,
    input  logic               rti_irq_mask_i,
    output logic               nmi_mask_o,
    output logic               irq_mask_o,
    output logic               take_o,
    output logic [1:0]         src_kind_o,
    output logic [IDX_W-1:0]   src_idx_o
);

    mask_bits_t       masks;
    mask_bits_t       rti_val;
    mask_bits_t       sw_val;
    logic             busy_q;
    src_kind_e        held_kind_q;
    src_kind_e        win_kind;
    logic             irq_hit;
    logic [IDX_W-1:0] irq_idx;
    logic             entry_set;

    assign rti_val = '{nmi_mask: rti_nmi_mask_i, irq_mask: rti_irq_mask_i};
    assign sw_val  = '{nmi_mask: sw_nmi_mask_i, irq_mask: sw_irq_mask_i};

    irq_prio_pick #(
        .NUM_REQ (NUM_IRQ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req_i (irq_req_i),
        .hit_o (irq_hit),
        .idx_o (irq_idx)
    );

    assign entry_set = stack_done_i & busy_q;

    irq_mask_reg u_masks (
        .clk          (clk),
        .rst          (rst),
        .entry_set_i  (entry_set),
        .entry_kind_i (held_kind_q),
        .rti_ld_i     (rti_i),
        .rti_val_i    (rti_val),
        .sw_wr_i      (sw_wr_i),
        .sw_val_i     (sw_val),
        .masks_o      (masks)
    );

    // Fixed order: non-maskable, then trap, then the maskable vector
    always_comb begin
        win_kind = SRC_NONE;
        if (!busy_q) begin
            if (nmi_req_i && !masks.nmi_mask) begin
                win_kind = SRC_NMI;
            end else if (trap_req_i) begin
                win_kind = SRC_TRAP;
            end else if (irq_hit && !masks.irq_mask) begin
                win_kind = SRC_MASKABLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            held_kind_q <= SRC_NONE;
        end else if (win_kind != SRC_NONE) begin
            busy_q      <= 1'b1;
            held_kind_q <= win_kind;
        end else if (entry_set) begin
            busy_q      <= 1'b0;
            held_kind_q <= SRC_NONE;
        end
    end

    assign take_o     = (win_kind != SRC_NONE);
    assign src_kind_o = win_kind;
    assign src_idx_o  = (win_kind == SRC_MASKABLE) ? irq_idx : '0;
    assign nmi_mask_o = masks.nmi_mask;
    assign irq_mask_o = masks.irq_mask;

    // R8: no take in the cycle after a take
    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    // R8: the flags hold between the take and the completion
    assert_masks_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !stack_done_i && !rti_i && !sw_wr_i) |=>
            ($stable(nmi_mask_o) && $stable(irq_mask_o)));

    // R5: an unmasked non-maskable request always wins the take
    assert_nmi_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (take_o && nmi_req_i && !nmi_mask_o) |-> (src_kind_o == SRC_NMI));

    // R6: no maskable source is forwarded while its flag is set
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        irq_mask_o |-> (src_kind_o != SRC_MASKABLE));

    // R7: the trap request is taken whenever the block is idle and nothing outranks it
    assert_trap_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (trap_req_i && !busy_q) |-> take_o);

endmodule

// File: tb/irq_mask_gate_tb_top.sv
`timescale 1ns/100ps
module irq_mask_gate_tb_top;

    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               nmi_req_i = 1'b0;
    logic               trap_req_i = 1'b0;
    logic [NUM_IRQ-1:0] irq_req_i = '0;
    logic               sw_wr_i = 1'b0;
    logic               sw_nmi_mask_i = 1'b0;
    logic               sw_irq_mask_i = 1'b0;
    logic               stack_done_i = 1'b0;
    logic               rti_i = 1'b0;
    logic               rti_nmi_mask_i = 1'b0;
    logic               rti_irq_mask_i = 1'b0;
    logic               nmi_mask_o;
    logic               irq_mask_o;
    logic               take_o;
    logic [1:0]         src_kind_o;
    logic [IDX_W-1:0]   src_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_gate #(.NUM_IRQ(NUM_IRQ)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .nmi_req_i      (nmi_req_i),
        .trap_req_i     (trap_req_i),
        .irq_req_i      (irq_req_i),
        .sw_wr_i        (sw_wr_i),
        .sw_nmi_mask_i  (sw_nmi_mask_i),
        .sw_irq_mask_i  (sw_irq_mask_i),
        .stack_done_i   (stack_done_i),
        .rti_i          (rti_i),
        .rti_nmi_mask_i (rti_nmi_mask_i),
        .rti_irq_mask_i (rti_irq_mask_i),
        .nmi_mask_o     (nmi_mask_o),
        .irq_mask_o     (irq_mask_o),
        .take_o         (take_o),
        .src_kind_o     (src_kind_o),
        .src_idx_o      (src_idx_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_masks(input string tag, input int x, input int i);
        check({tag, " nmi flag"}, int'(nmi_mask_o), x);
        check({tag, " irq flag"}, int'(irq_mask_o), i);
    endtask

    task automatic sw_write(input logic x, input logic i);
        sw_wr_i = 1'b1; sw_nmi_mask_i = x; sw_irq_mask_i = i;
        @(negedge clk);
        sw_wr_i = 1'b0;
    endtask

    task automatic restore(input logic x, input logic i);
        rti_i = 1'b1; rti_nmi_mask_i = x; rti_irq_mask_i = i;
        @(negedge clk);
        rti_i = 1'b0;
    endtask

    task automatic pulse_stack_done();
        stack_done_i = 1'b1;
        @(negedge clk);
        stack_done_i = 1'b0;
    endtask

    task automatic t_reset();
        nmi_req_i = 1'b1; irq_req_i = '1;
        #1;
        check_masks("R1 reset", 1, 1);
        check("R1 no take after reset", int'(take_o), 0);
        nmi_req_i = 1'b0; irq_req_i = '0;
        @(negedge clk);
    endtask

    task automatic t_sw_write();
        sw_write(1'b0, 1'b1);
        check_masks("R2 sw clear nmi flag", 0, 1);
        sw_write(1'b1, 1'b0);
        check("R2 sw set of nmi flag ignored", int'(nmi_mask_o), 0);
        check("R3 sw clear irq flag", int'(irq_mask_o), 0);
        sw_write(1'b1, 1'b1);
        check_masks("R3 sw set irq flag", 0, 1);
    endtask

    task automatic t_nmi();
        nmi_req_i = 1'b1; trap_req_i = 1'b1; irq_req_i = 8'h0F;
        #1;
        check("R4 nmi taken with irq flag set", int'(take_o), 1);
        check("R5 nmi outranks trap and maskable", int'(src_kind_o), 3);
        @(negedge clk);
        trap_req_i = 1'b0; irq_req_i = '0;
        check("R8 no take while busy", int'(take_o), 0);
        check_masks("R8 flags held while busy", 0, 1);
        @(negedge clk);
        check("R8 still busy without stack done", int'(take_o), 0);
        pulse_stack_done();
        check_masks("R10 nmi entry sets both", 1, 1);
        check("R4 nmi blocked by its flag", int'(take_o), 0);
        nmi_req_i = 1'b0;
    endtask

    task automatic t_restore();
        restore(1'b0, 1'b0);
        check_masks("R11 restore zeros", 0, 0);
        restore(1'b1, 1'b0);
        check_masks("R11 restore sets nmi flag", 1, 0);
        restore(1'b0, 1'b1);
        check_masks("R11 restore mixed", 0, 1);
    endtask

    task automatic t_trap();
        restore(1'b1, 1'b1);
        trap_req_i = 1'b1; irq_req_i = '1;
        #1;
        check("R7 trap taken with both flags set", int'(take_o), 1);
        check("R7 trap kind", int'(src_kind_o), 2);
        @(negedge clk);
        trap_req_i = 1'b0; irq_req_i = '0;
        pulse_stack_done();
        check_masks("R9 trap entry keeps nmi flag 1", 1, 1);
        restore(1'b0, 1'b0);
        trap_req_i = 1'b1; irq_req_i = 8'h01;
        #1;
        check("R7 trap outranks maskable", int'(src_kind_o), 2);
        @(negedge clk);
        trap_req_i = 1'b0; irq_req_i = '0;
        pulse_stack_done();
        check_masks("R9 trap entry keeps nmi flag 0", 0, 1);
    endtask

    task automatic t_maskable();
        restore(1'b0, 1'b0);
        irq_req_i = 8'b0110_0110;
        #1;
        check("R6 maskable kind", int'(src_kind_o), 1);
        check("R6 lowest index wins", int'(src_idx_o), 1);
        irq_req_i = 8'b1000_0000;
        #1;
        check("R6 top index alone", int'(src_idx_o), 7);
        @(negedge clk);
        irq_req_i = 8'b0001_1000;
        check("R8 no maskable take while busy", int'(take_o), 0);
        pulse_stack_done();
        check_masks("R9 maskable entry sets irq flag only", 0, 1);
        check("R6 maskable blocked by irq flag", int'(take_o), 0);
        sw_write(1'b0, 1'b0);
        #1;
        check("R6 index after unmask", int'(src_idx_o), 3);
        irq_req_i = '0;
        #1;
        check("R6 no take without requests", int'(take_o), 0);
    endtask

    task automatic t_stray_and_order();
        stack_done_i = 1'b1;
        @(negedge clk);
        stack_done_i = 1'b0;
        check_masks("R12 stray stack done ignored", 0, 0);
        rti_i = 1'b1; rti_nmi_mask_i = 1'b1; rti_irq_mask_i = 1'b0;
        sw_wr_i = 1'b1; sw_nmi_mask_i = 1'b0; sw_irq_mask_i = 1'b1;
        @(negedge clk);
        rti_i = 1'b0; sw_wr_i = 1'b0;
        check_masks("R13 restore beats sw write", 1, 0);
        restore(1'b0, 1'b0);
        trap_req_i = 1'b1;
        #1;
        check("R13 trap take for entry order", int'(take_o), 1);
        @(negedge clk);
        trap_req_i = 1'b0;
        stack_done_i = 1'b1; rti_i = 1'b1; rti_nmi_mask_i = 1'b0; rti_irq_mask_i = 1'b0;
        @(negedge clk);
        stack_done_i = 1'b0; rti_i = 1'b0;
        check_masks("R13 entry completion beats restore", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_write();
        t_nmi();
        t_restore();
        t_trap();
        t_maskable();
        t_stray_and_order();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule